// File: doc/BRIEF.md
# Extended Multi-PHY Cell-Available Poller

This block is the master-side poller for a cell bus that reaches up to 248 PHY ports through a 5-bit address. While polling is enabled, it steps a poll address through the 31 usable values 0 to 30. One cycle after each address has been on the bus, it captures every cell-available line in parallel. Line `g` reports sub-port group `g`, so each poll address yields eight answers, and together they fill a 248-bit availability map.

The block also forms the full 8-bit port number of a cell. The low five bits are the bus address. The high three bits are a sub-port field carried in a configurable byte of the cell prefix. On the transmit side the block places the field into the prefix and drives the bus address. On the receive side it lifts the field out and joins it with the bus address. A standard mode uses only line 0 and so covers 31 ports.

Top module: `clav_poller`

## Requirements
- R1: During and directly after reset, `poll_addr` is 31, `avail_map` is all zeros and `map_valid` is low.
- R2: When `poll_en` is low at a clock edge, `poll_addr` is 31 (the null address) from that edge on.
- R3: While `poll_en` is high, `poll_addr` steps 0, 1, ..., 30 and then wraps to 0. Leaving the null address always goes to 0, so a pass that is interrupted restarts at 0.
- R4: Suppose `poll_addr` is `a` (not 31) in cycle n. Then `clav_in` during cycle n+1 is captured at the end of that cycle, and bit `g*31+a` of `avail_map` takes `clav_in[g]`.
- R5: With `ext_mode` low, only `clav_in[0]` is used. Map bits for groups 1 to 7 are written 0 whatever those lines carry. With `ext_mode` high, all eight lines are used.
- R6: `map_valid` is a one-cycle pulse. It is high in the cycle in which `avail_map` first shows the result for address 30. At that point the map holds one complete pass.
- R7: The sub-port field sits in byte `pfx_sel` of the 32-bit prefix, where byte n is bits 8n+7..8n. Byte 0 is the user prepend, byte 1 a header byte, and bytes 2 and 3 the two user-defined bytes. Field bit k sits at byte bit (`sub_off`+k) mod 8.
- R8: `tx_bus_addr` equals `tx_port[4:0]`. `tx_pfx_out` equals `tx_pfx_in` with the three field positions of R7 replaced by `tx_port[7:5]`, and every other bit is unchanged.
- R9: `rx_port[4:0]` equals `rx_addr`, and `rx_port[7:5]` holds the field read from `rx_pfx` at the positions of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_en | input | 1 | Polling enable |
| ext_mode | input | 1 | 1: eight cell-available lines, 0: line 0 only |
| pfx_sel | input | 2 | Prefix byte that carries the sub-port field |
| sub_off | input | 3 | Bit offset of the field inside that byte |
| clav_in | input | 8 | Cell-available lines, one per sub-port group |
| poll_addr | output | 5 | Poll address on the bus, 31 when idle |
| avail_map | output | 248 | Availability map, bit g*31+a |
| map_valid | output | 1 | Pulse when a full pass completes |
| tx_port | input | 8 | Port number of a cell to send |
| tx_pfx_in | input | 32 | Outgoing cell prefix before insertion |
| tx_pfx_out | output | 32 | Outgoing prefix with the sub-port field inserted |
| tx_bus_addr | output | 5 | Bus address for the outgoing cell |
| rx_addr | input | 5 | Bus address of a received cell |
| rx_pfx | input | 32 | Received cell prefix |
| rx_port | output | 8 | Full port number of the received cell |

## Verification
The bench answers each poll address from a model of the PHY side. The model drives the lines for the address seen one cycle earlier. A poller that sampled one cycle too early or too late would write each answer to the neighbouring address, which shows up as shifted bits in the map. Full passes are compared in both modes and with two line patterns. Standard mode is run with the upper lines held active, so a map that leaked those lines would show stray ones. The bench also interrupts polling mid-pass and checks the null address and the restart at 0; a counter that resumed where it stopped would fail this. It sweeps every prefix byte, every offset and every port value through insertion and extraction. The offsets 6 and 7 are included, where the field wraps inside its byte, so an implementation that spilled into the next byte would corrupt neighbouring bits.

// File: rtl/clav_poller.sv
module clav_poller #(
  parameter int ADDR_W    = 5,
  parameter int NUM_CLAV  = 8,
  parameter int PFX_BYTES = 4
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         poll_en,
  input  logic                                         ext_mode,
  input  logic [$clog2(PFX_BYTES)-1:0]                 pfx_sel,
  input  logic [2:0]                                   sub_off,
  input  logic [NUM_CLAV-1:0]                          clav_in,
  output logic [ADDR_W-1:0]                            poll_addr,
  output logic [((1<<ADDR_W)-1)*NUM_CLAV-1:0]          avail_map,
  output logic                                         map_valid,
  input  logic [ADDR_W+$clog2(NUM_CLAV)-1:0]           tx_port,
  input  logic [8*PFX_BYTES-1:0]                       tx_pfx_in,
  output logic [8*PFX_BYTES-1:0]                       tx_pfx_out,
  output logic [ADDR_W-1:0]                            tx_bus_addr,
  input  logic [ADDR_W-1:0]                            rx_addr,
  input  logic [8*PFX_BYTES-1:0]                       rx_pfx,
  output logic [ADDR_W+$clog2(NUM_CLAV)-1:0]           rx_port
);
  localparam int SUB_W    = $clog2(NUM_CLAV);
  localparam int NUM_ADDR = (1 << ADDR_W) - 1;
  localparam logic [ADDR_W-1:0] NULL_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_ADDR - 1);

  logic [ADDR_W-1:0] pend_addr;
  logic              pend_vld;
  logic [SUB_W-1:0]  rx_sub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poll_addr <= NULL_ADDR;
      pend_addr <= '0;
      pend_vld  <= 1'b0;
      map_valid <= 1'b0;
      avail_map <= '0;
    end else begin
      if (!poll_en)
        poll_addr <= NULL_ADDR;
      else if (poll_addr == NULL_ADDR || poll_addr == LAST_ADDR)
        poll_addr <= '0;
      else
        poll_addr <= poll_addr + 1'b1;
      pend_addr <= poll_addr;
      pend_vld  <= (poll_addr != NULL_ADDR);
      map_valid <= pend_vld && (pend_addr == LAST_ADDR);
      if (pend_vld)
        for (int g = 0; g < NUM_CLAV; g++)
          avail_map[g*NUM_ADDR + int'(pend_addr)] <= clav_in[g] & (ext_mode | (g == 0));
    end
  end

  assign tx_bus_addr = tx_port[ADDR_W-1:0];

  always_comb begin
    tx_pfx_out = tx_pfx_in;
    for (int k = 0; k < SUB_W; k++)
      tx_pfx_out[int'(pfx_sel)*8 + ((int'(sub_off) + k) & 7)] = tx_port[ADDR_W + k];
  end

  always_comb begin
    rx_sub = '0;
    for (int k = 0; k < SUB_W; k++)
      rx_sub[k] = rx_pfx[int'(pfx_sel)*8 + ((int'(sub_off) + k) & 7)];
  end

  assign rx_port = {rx_sub, rx_addr};
endmodule

module clav_poller_chk #(
  parameter int ADDR_W   = 5,
  parameter int NUM_CLAV = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              poll_en,
  input logic [ADDR_W-1:0] poll_addr,
  input logic              map_valid
);
  localparam logic [ADDR_W-1:0] NULL_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((1 << ADDR_W) - 2);

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (poll_addr == NULL_ADDR) && !map_valid);

  a_r2_idle_null: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_en |=> poll_addr == NULL_ADDR);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_en && poll_addr < LAST_ADDR) |=> poll_addr == $past(poll_addr) + 1'b1);

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_en && (poll_addr == LAST_ADDR || poll_addr == NULL_ADDR)) |=> poll_addr == '0);

  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |=> !map_valid);

  a_r6_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |-> $past(poll_addr, 2) == LAST_ADDR);
endmodule

bind clav_poller clav_poller_chk #(.ADDR_W(ADDR_W), .NUM_CLAV(NUM_CLAV)) u_chk (
  .clk(clk), .rst_n(rst_n), .poll_en(poll_en),
  .poll_addr(poll_addr), .map_valid(map_valid)
);

// File: tb/clav_poller_bench.sv
module clav_poller_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         poll_en = 1'b0;
  logic         ext_mode = 1'b1;
  logic [1:0]   pfx_sel = '0;
  logic [2:0]   sub_off = '0;
  logic [7:0]   clav_in = '0;
  logic [4:0]   poll_addr;
  logic [247:0] avail_map;
  logic         map_valid;
  logic [7:0]   tx_port = '0;
  logic [31:0]  tx_pfx_in = '0;
  logic [31:0]  tx_pfx_out;
  logic [4:0]   tx_bus_addr;
  logic [4:0]   rx_addr = '0;
  logic [31:0]  rx_pfx = '0;
  logic [7:0]   rx_port;

  int checks = 0;
  int errors = 0;
  int seed = 0;
  bit done = 0;

  clav_poller u_clav_poller (
    .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .ext_mode(ext_mode),
    .pfx_sel(pfx_sel), .sub_off(sub_off), .clav_in(clav_in),
    .poll_addr(poll_addr), .avail_map(avail_map), .map_valid(map_valid),
    .tx_port(tx_port), .tx_pfx_in(tx_pfx_in), .tx_pfx_out(tx_pfx_out),
    .tx_bus_addr(tx_bus_addr), .rx_addr(rx_addr), .rx_pfx(rx_pfx), .rx_port(rx_port)
  );

  always #4 clk = ~clk;

  function automatic bit pat(int a, int g, int s);
    return ((a * 5 + g * 11 + s) % 3) == 0;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // PHY model (R4): answers during the cycle after it saw an address
  initial begin
    logic [4:0] last = 5'd31;
    forever begin
      @(negedge clk);
      clav_in = 8'h00;
      if (last != 5'd31)
        for (int g = 0; g < 8; g++) clav_in[g] = pat(int'(last), g, seed);
      last = poll_addr;
    end
  end

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 100 && !got; i++) begin
      @(negedge clk);
      if (map_valid) got = 1;
    end
  endtask

  task automatic check_map(string req);
    bit good = 1;
    longint a_bad = 0, e_bad = 0;
    for (int g = 0; g < 8; g++)
      for (int a = 0; a < 31; a++) begin
        bit exp = pat(a, g, seed) & (ext_mode | (g == 0));
        if (avail_map[g*31 + a] !== exp && good) begin
          good = 0; a_bad = avail_map[g*31 + a]; e_bad = exp;
          $display("  map mismatch at group %0d address %0d", g, a);
        end
      end
    check(good, req, a_bad, e_bad);
  endtask

  task automatic full_pass(string req);
    bit got;
    wait_valid(got);
    check(got, "R6 first pulse", got, 1);
    wait_valid(got);
    check(got, "R6 second pulse", got, 1);
    check_map(req);
    @(negedge clk);
    check(!map_valid, "R6 pulse width", map_valid, 0);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(poll_addr == 5'd31, "R1 poll_addr", poll_addr, 31);
    check(avail_map == '0, "R1 map", 0, 0);
    check(!map_valid, "R1 valid", map_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(poll_addr == 5'd31, "R2 idle", poll_addr, 31);

    poll_en = 1'b1;
    @(negedge clk);
    check(poll_addr == 5'd0, "R3 start at 0", poll_addr, 0);
    for (int i = 1; i < 40; i++) begin
      @(negedge clk);
      check(poll_addr == 5'(i % 31), "R3 sequence", poll_addr, i % 31);
    end

    // R4 / R5 extended mode, two patterns
    ext_mode = 1'b1; seed = 0;
    full_pass("R4 ext seed0");
    seed = 1;
    full_pass("R4 ext seed1");
    // R5 standard mode; upper lines still driven by the model
    ext_mode = 1'b0; seed = 2;
    full_pass("R5 standard mode");
    ext_mode = 1'b1;

    // R2/R3 interrupt and restart
    while (poll_addr != 5'd10) @(negedge clk);
    poll_en = 1'b0;
    @(negedge clk);
    check(poll_addr == 5'd31, "R2 null after disable", poll_addr, 31);
    @(negedge clk);
    check(poll_addr == 5'd31, "R2 null held", poll_addr, 31);
    poll_en = 1'b1;
    @(negedge clk);
    check(poll_addr == 5'd0, "R3 restart at 0", poll_addr, 0);
    seed = 0;
    full_pass("R4 after restart");

    // R7/R8/R9 insertion and extraction sweep
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o++)
        for (int p = 0; p < 256; p++) begin
          logic [31:0] exp_pfx, base;
          logic [2:0] exp_sub;
          base = 32'(p) * 32'h9E3779B1 ^ 32'(s * 8 + o) * 32'h01010101;
          pfx_sel = 2'(s); sub_off = 3'(o);
          tx_port = 8'(p); tx_pfx_in = base;
          rx_addr = 5'(p + 3); rx_pfx = base;
          exp_pfx = base;
          for (int k = 0; k < 3; k++) begin
            exp_pfx[s*8 + ((o + k) % 8)] = tx_port[5 + k];
            exp_sub[k] = base[s*8 + ((o + k) % 8)];
          end
          #1;
          check(tx_bus_addr == 5'(p), "R8 bus address", tx_bus_addr, p % 32);
          check(tx_pfx_out == exp_pfx, "R7 R8 insert", tx_pfx_out, exp_pfx);
          check(rx_port == {exp_sub, rx_addr}, "R7 R9 extract", rx_port, {exp_sub, rx_addr});
        end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule